// File: doc/BRIEF.md
# Valid Route Table Collector

This unit sits beside one edge I/O port of a core array and gathers the routes found by discovery. At startup, and again whenever a programmable period has run out, it issues a one-cycle route request tagged with a new sequence number. The flooding network that carries the request is outside this block. While the collection window is open, the unit takes in the acknowledgements that come back. For each core that answers for the first time with the current sequence number, it stores the route in a table indexed by core ID.

When the window closes, a completion flag rises. The flag holds the number of distinct cores that answered until the next round begins, and test flows use that number to grade and sort the chip. A combinational lookup port returns the stored route for any core ID, so later traffic from the port can reuse it. A core without an entry reads back as a miss.

Top module: `route_table_collector`

## Requirements
- R1: Out of reset, `req_valid`, `round_done` and `core_count` are 0. The first request pulse appears in the first clock cycle after reset is released. `req_valid` is never high for two cycles in a row.
- R2: Each request carries a sequence number one above the previous one, modulo 2^SEQ_W. The first request carries 1. In the cycle the request is high, `core_count` is 0 and every lookup misses.
- R3: An acknowledgement is accepted only when four things hold: the window is open, `ack_seq` equals the current sequence number, `ack_core` is below NUM_CORES, and that core has no entry yet. An accepted route can be read through the lookup port from the next cycle on. All other acknowledgements change nothing.
- R4: `core_count` equals the number of distinct cores accepted in the current round.
- R5: A repeat acknowledgement from a core that already has an entry neither replaces its stored route nor raises the count.
- R6: The collection window is the `timeout_cycles` cycles that start with the request cycle. A value of 0 acts as 1. `round_done` goes high in the cycle after the window, and acknowledgements from then on are ignored.
- R7: While `round_done` is high, `core_count` and the table stay unchanged. The flag stays high until the next round starts.
- R8: With `period_cycles` = 0, no further round starts. Otherwise `round_done` falls after `period_cycles` cycles with the flag high, and the next request appears one cycle later. For a period set while the flag is already high, the count runs from the cycle after the setting.
- R9: A lookup of a core ID with no entry in the current round returns `lkp_hit` = 0 and `lkp_route` = 0. This also covers IDs at or above NUM_CORES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timeout_cycles | input | TMO_W (16) | Length of the collection window in cycles |
| period_cycles | input | PER_W (20) | Cycles from completion to the next round; 0 turns off repeats |
| req_valid | output | 1 | One-cycle route request pulse |
| req_seq | output | SEQ_W (8) | Sequence number of the current round |
| ack_valid | input | 1 | Acknowledgement present |
| ack_seq | input | SEQ_W (8) | Sequence number echoed by the acknowledgement |
| ack_core | input | ID_W (4) | ID of the responding core |
| ack_route | input | ROUTE_W (16) | Route recorded along the request path |
| lkp_core | input | ID_W (4) | Core ID to look up |
| lkp_hit | output | 1 | Lookup found a valid entry |
| lkp_route | output | ROUTE_W (16) | Stored route, 0 on a miss |
| core_count | output | CNT_W (4) | Distinct cores that answered this round |
| round_done | output | 1 | Collection window closed; count is final |

## Verification
A corrupted valid bit or stored route shows up at the lookup port in the very next cycle. The mismatch is either a hit where a miss is due, or a route differing from the first one reported. A counter that drifts from the table, or that grows on a repeat, shows up on `core_count` one cycle after the acknowledgement that caused it. A window or period counter that is off by one moves the edge of `round_done` or `req_valid` by exactly one cycle. For that reason the bench times those edges from the request cycle and from the rise of the flag, not only their eventual values.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef enum logic [1:0] {
        ST_START   = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DONE    = 2'd2
    } rtc_state_e;
endpackage

// File: rtl/rtc_table.sv
module rtc_table #(
    parameter int NUM_CORES = 12,
    parameter int ID_W      = 4,
    parameter int ROUTE_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [ID_W-1:0]      wr_idx,
    input  logic [ROUTE_W-1:0]   wr_route,
    input  logic [ID_W-1:0]      probe_idx,
    output logic                 probe_valid,
    input  logic [ID_W-1:0]      rd_idx,
    output logic                 rd_hit,
    output logic [ROUTE_W-1:0]   rd_route,
    output logic [NUM_CORES-1:0] valid_vec
);
    logic [NUM_CORES-1:0] valid_d, valid_q;
    logic [ROUTE_W-1:0]   route_d [NUM_CORES];
    logic [ROUTE_W-1:0]   route_q [NUM_CORES];

    always_comb begin
        valid_d = valid_q;
        route_d = route_q;
        if (clr) begin
            valid_d = '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_CORES; i++) begin
                if (wr_idx == ID_W'(i)) begin
                    valid_d[i] = 1'b1;
                    route_d[i] = wr_route;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            route_q <= '{default: '0};
        end else begin
            valid_q <= valid_d;
            route_q <= route_d;
        end
    end

    always_comb begin
        rd_hit      = 1'b0;
        rd_route    = '0;
        probe_valid = 1'b0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (rd_idx == ID_W'(i) && valid_q[i]) begin
                rd_hit   = 1'b1;
                rd_route = route_q[i];
            end
            if (probe_idx == ID_W'(i)) begin
                probe_valid = valid_q[i];
            end
        end
    end

    assign valid_vec = valid_q;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_keep
        AST_ROUTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_q[g] && !clr) |=> $stable(route_q[g])); // R5
    end
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
    import rtc_pkg::*;
#(
    parameter int NUM_CORES = 12,
    parameter int ID_W      = 4,
    parameter int SEQ_W     = 8,
    parameter int CNT_W     = 4,
    parameter int TMO_W     = 16,
    parameter int PER_W     = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMO_W-1:0] timeout_cycles,
    input  logic [PER_W-1:0] period_cycles,
    input  logic             ack_valid,
    input  logic [SEQ_W-1:0] ack_seq,
    input  logic [ID_W-1:0]  ack_core,
    input  logic             ent_valid,
    output logic             tbl_clr,
    output logic             tbl_wr,
    output logic             req_valid,
    output logic [SEQ_W-1:0] req_seq,
    output logic             round_done,
    output logic [CNT_W-1:0] core_count
);
    typedef struct packed {
        rtc_state_e       st;
        logic [SEQ_W-1:0] seq;
        logic [CNT_W-1:0] cnt;
        logic [TMO_W-1:0] tmo;
        logic [PER_W-1:0] per;
        logic             req;
        logic             done;
    } ctrl_s;

    ctrl_s r_d, r_q;
    logic  accept;

    always_comb begin
        r_d     = r_q;
        r_d.req = 1'b0;
        tbl_clr = 1'b0;
        tbl_wr  = 1'b0;
        accept  = ack_valid && (ack_seq == r_q.seq) && !ent_valid
                  && ({1'b0, ack_core} < (ID_W+1)'(NUM_CORES));
        case (r_q.st)
            ST_START: begin
                r_d.seq  = r_q.seq + 1'b1;
                r_d.cnt  = '0;
                r_d.tmo  = '0;
                r_d.per  = '0;
                r_d.req  = 1'b1;
                r_d.done = 1'b0;
                r_d.st   = ST_COLLECT;
                tbl_clr  = 1'b1;
            end
            ST_COLLECT: begin
                if (accept) begin
                    tbl_wr  = 1'b1;
                    r_d.cnt = r_q.cnt + 1'b1;
                end
                if (({1'b0, r_q.tmo} + 1'b1) >= {1'b0, timeout_cycles}) begin
                    r_d.st   = ST_DONE;
                    r_d.done = 1'b1;
                    r_d.per  = '0;
                end else begin
                    r_d.tmo = r_q.tmo + 1'b1;
                end
            end
            ST_DONE: begin
                if (period_cycles == '0) begin
                    r_d.per = '0;
                end else if (({1'b0, r_q.per} + 1'b1) >= {1'b0, period_cycles}) begin
                    r_d.st   = ST_START;
                    r_d.done = 1'b0;
                end else begin
                    r_d.per = r_q.per + 1'b1;
                end
            end
            default: r_d.st = ST_START;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_START, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_valid  = r_q.req;
    assign req_seq    = r_q.seq;
    assign round_done = r_q.done;
    assign core_count = r_q.cnt;

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.req |=> !r_q.req); // R1
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.req |-> (r_q.seq == SEQ_W'($past(r_q.seq) + 1'b1))); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CNT_W'(NUM_CORES)); // R4
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done && $past(r_q.done)) |-> $stable(r_q.cnt)); // R7
endmodule

// File: rtl/route_table_collector.sv
module route_table_collector #(
    parameter int NUM_CORES = 12,
    parameter int ROUTE_W   = 16,
    parameter int SEQ_W     = 8,
    parameter int TMO_W     = 16,
    parameter int PER_W     = 20,
    localparam int ID_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int CNT_W    = $clog2(NUM_CORES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TMO_W-1:0]   timeout_cycles,
    input  logic [PER_W-1:0]   period_cycles,
    output logic               req_valid,
    output logic [SEQ_W-1:0]   req_seq,
    input  logic               ack_valid,
    input  logic [SEQ_W-1:0]   ack_seq,
    input  logic [ID_W-1:0]    ack_core,
    input  logic [ROUTE_W-1:0] ack_route,
    input  logic [ID_W-1:0]    lkp_core,
    output logic               lkp_hit,
    output logic [ROUTE_W-1:0] lkp_route,
    output logic [CNT_W-1:0]   core_count,
    output logic               round_done
);
    logic                 tbl_clr, tbl_wr, ent_valid;
    logic [NUM_CORES-1:0] valid_vec;

    rtc_ctrl #(
        .NUM_CORES(NUM_CORES), .ID_W(ID_W), .SEQ_W(SEQ_W),
        .CNT_W(CNT_W), .TMO_W(TMO_W), .PER_W(PER_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .timeout_cycles(timeout_cycles), .period_cycles(period_cycles),
        .ack_valid(ack_valid), .ack_seq(ack_seq), .ack_core(ack_core),
        .ent_valid(ent_valid), .tbl_clr(tbl_clr), .tbl_wr(tbl_wr),
        .req_valid(req_valid), .req_seq(req_seq),
        .round_done(round_done), .core_count(core_count)
    );

    rtc_table #(
        .NUM_CORES(NUM_CORES), .ID_W(ID_W), .ROUTE_W(ROUTE_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .clr(tbl_clr),
        .wr_en(tbl_wr), .wr_idx(ack_core), .wr_route(ack_route),
        .probe_idx(ack_core), .probe_valid(ent_valid),
        .rd_idx(lkp_core), .rd_hit(lkp_hit), .rd_route(lkp_route),
        .valid_vec(valid_vec)
    );

    AST_COUNT_TRACKS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_count == CNT_W'($countones(valid_vec))); // R4
    AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (valid_vec == '0)); // R2
endmodule

// File: tb/route_table_collector_test.sv
`timescale 1ns/1ps
module route_table_collector_test;
    localparam int NC = 12;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] timeout_cycles;
    logic [19:0] period_cycles;
    logic        req_valid;
    logic [7:0]  req_seq;
    logic        ack_valid;
    logic [7:0]  ack_seq;
    logic [3:0]  ack_core;
    logic [15:0] ack_route;
    logic [3:0]  lkp_core;
    logic        lkp_hit;
    logic [15:0] lkp_route;
    logic [3:0]  core_count;
    logic        round_done;

    int checks = 0;
    int fails  = 0;
    bit          exp_valid [16];
    logic [15:0] exp_route [16];
    int          exp_cnt;
    logic [7:0]  cur_seq;
    int          tcur;

    always #2.5 clk = ~clk;

    route_table_collector uut (
        .clk(clk), .rst_n(rst_n), .timeout_cycles(timeout_cycles),
        .period_cycles(period_cycles), .req_valid(req_valid), .req_seq(req_seq),
        .ack_valid(ack_valid), .ack_seq(ack_seq), .ack_core(ack_core),
        .ack_route(ack_route), .lkp_core(lkp_core), .lkp_hit(lkp_hit),
        .lkp_route(lkp_route), .core_count(core_count), .round_done(round_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit accepts(input logic [7:0] s, input int c);
        return (s == cur_seq) && (c < NC) && !exp_valid[c];
    endfunction

    function automatic int fresh_core();
        for (int i = 0; i < NC; i++) if (!exp_valid[i]) return i;
        return -1;
    endfunction

    task automatic clear_model();
        for (int i = 0; i < 16; i++) begin exp_valid[i] = 0; exp_route[i] = '0; end
        exp_cnt = 0;
    endtask

    task automatic drive_ack(input logic [7:0] s, input int c, input logic [15:0] rt);
        ack_valid = 1'b1; ack_seq = s; ack_core = 4'(c); ack_route = rt;
        if (accepts(s, c)) begin
            exp_valid[c] = 1; exp_route[c] = rt; exp_cnt++;
        end
    endtask

    task automatic check_table(input string tag);
        for (int i = 0; i < 16; i++) begin
            lkp_core = 4'(i);
            #0.1;
            chk({tag, " R9/R3 hit"}, 32'(lkp_hit), 32'(exp_valid[i]));
            chk({tag, " R9/R3 route"}, 32'(lkp_route), exp_valid[i] ? 32'(exp_route[i]) : 32'h0);
        end
        chk({tag, " R4 count"}, 32'(core_count), 32'(exp_cnt));
    endtask

    task automatic wait_req(output int n);
        n = 0;
        while (!req_valid && n < 5000) begin @(negedge clk); n++; end
    endtask

    // Called at the negedge of the request cycle (window cycle 0).
    task automatic collect(input int n_rand, input bit directed, input bit probe);
        int c;
        for (int k = 0; k < tcur; k++) begin
            ack_valid = 1'b0;
            if (directed && k == 0) drive_ack(cur_seq, 3, 16'hA5A5);
            else if (directed && k == 1) drive_ack(cur_seq, 3, 16'h5A5A); // R5 repeat
            else if (directed && k == 2) drive_ack(cur_seq - 8'd1, 4, 16'h1111); // R3 stale seq
            else if (directed && k == 3) drive_ack(cur_seq, 13, 16'h2222); // R3 out of range
            else if (k < n_rand) begin
                logic [7:0] s;
                s = ($urandom % 4 != 0) ? cur_seq : cur_seq + 8'(1 + $urandom % 3);
                drive_ack(s, int'($urandom % 16), 16'($urandom));
            end else if (probe && k == tcur - 1) begin
                c = fresh_core();
                if (c >= 0) drive_ack(cur_seq, c, 16'hBEEF); // R6 last window cycle
            end
            @(negedge clk);
            ack_valid = 1'b0;
            if (k + 1 < tcur) chk("R6 done low in window", 32'(round_done), 32'h0);
            chk("R4 running count", 32'(core_count), 32'(exp_cnt));
        end
        chk("R6 done after window", 32'(round_done), 32'h1);
        if (probe) begin
            c = fresh_core();
            if (c >= 0) begin
                ack_valid = 1'b1; ack_seq = cur_seq; ack_core = 4'(c); ack_route = 16'hDEAD;
                @(negedge clk);
                ack_valid = 1'b0;
                chk("R6 late ack count", 32'(core_count), 32'(exp_cnt));
                lkp_core = 4'(c); #0.1;
                chk("R6 late ack lookup", 32'(lkp_hit), 32'h0);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'h5EED));
        rst_n = 1'b0; timeout_cycles = 16'd40; period_cycles = '0;
        ack_valid = 1'b0; ack_seq = '0; ack_core = '0; ack_route = '0; lkp_core = '0;
        tcur = 40;
        clear_model();
        repeat (3) @(negedge clk);
        chk("R1 reset req", 32'(req_valid), 0);
        chk("R1 reset done", 32'(round_done), 0);
        chk("R1 reset count", 32'(core_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first req", 32'(req_valid), 1);
        chk("R2 first seq", 32'(req_seq), 1);
        cur_seq = 8'd1;
        collect(30, 1'b1, 1'b1);
        chk("R5 repeat keeps route", 32'(exp_route[3]), 32'hA5A5);
        check_table("round1");

        // R7/R8: period 0 -> flag and table held, no request.
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (req_valid) n++;
            chk("R7 done held", 32'(round_done), 1);
        end
        chk("R8 no repeat with period 0", 32'(n), 0);
        check_table("held");

        // R8: period set while done.
        period_cycles = 20'd7;
        n = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); n++; if (req_valid) break; end
        chk("R8 request after period", 32'(req_valid), 1);
        chk("R8 delay", 32'(n), 8);
        chk("R2 seq step", 32'(req_seq), 2);
        chk("R2 count cleared", 32'(core_count), 0);
        lkp_core = 4'd3; #0.1;
        chk("R2 table cleared", 32'(lkp_hit), 0);
        cur_seq = 8'd2; clear_model();
        collect(10, 1'b0, 1'b0);
        check_table("round2");
        n = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); n++; if (req_valid) break; end
        chk("R8 periodic spacing", 32'(n), 8);
        chk("R2 seq step 3", 32'(req_seq), 3);
        period_cycles = '0;
        cur_seq = 8'd3; clear_model();
        collect(35, 1'b1, 1'b1);
        check_table("round3");

        // R6 boundary: timeout 0 behaves as a one-cycle window.
        timeout_cycles = '0; tcur = 1; period_cycles = 20'd2;
        for (int r = 0; r < 5; r++) begin
            wait_req(n);
            chk("R1 request seen", 32'(req_valid), 1);
            chk("R2 seq step short", 32'(req_seq), 32'(cur_seq + 8'd1));
            cur_seq = cur_seq + 8'd1; clear_model();
            if (r == 4) period_cycles = '0;
            collect(1, 1'b0, 1'b1);
            check_table("short");
        end
        repeat (10) @(negedge clk);
        chk("R7 final hold", 32'(round_done), 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule